// File: doc/BRIEF.md
# Mirrored Special Register File

This block is the internal data store of an 8-bit microcontroller core: 256 bytes of byte-addressable memory with one write port and one read port. A handful of locations that the core uses constantly (the accumulator, the stack pointer, both halves of the data pointer, the status word, and the two pointer registers of the active register bank) are also held in dedicated flops. Those flops drive outputs directly, so the surrounding datapath can use them as operands or as indirect addresses without spending a cycle on a memory read.

Every write goes through the single write port. The addressed byte is updated, and if that address belongs to a mirrored location the dedicated copy is updated at the same clock edge, so the two never disagree. The two bank pointer registers live at bank*8+0 and bank*8+1, where the bank comes from bits 4:3 of the status word. When the status word is written, both pointer copies are reloaded from the locations of the newly selected bank at that same edge.

Top module: `mirror_regfile`

## Requirements
- R1: Reset is synchronous and active high. After reset `sp_q` is 0x07 and `acc_q`, `dptr_q`, `psw_q`, `r0_q`, `r1_q` are zero, and reading addresses 0x81 gives 0x07 while 0xE0, 0x82, 0x83, 0xD0, 0x00 and 0x01 give 0x00.
- R2: With `wr_en` high, `wr_data` is stored at `wr_addr` on the rising edge, and a later read of that address returns it.
- R3: `rd_data` is combinational from `rd_addr`; when `wr_en` is high and `wr_addr` equals `rd_addr`, it returns `wr_data` in that same cycle (write-first).
- R4: A write to 0xE0 updates `acc_q` at the same edge as the memory byte.
- R5: A write to 0x81 updates `sp_q` at the same edge as the memory byte.
- R6: Writes to 0x82 and 0x83 update bits 7:0 and 15:8 of `dptr_q` respectively, at the same edge.
- R7: A write to 0xD0 updates `psw_q` at the same edge; bits 4:3 of `psw_q` select the active bank 0 to 3.
- R8: A write to active-bank address bank*8+0 updates `r0_q`, and to bank*8+1 updates `r1_q`, at the same edge; writes to another bank's pointer addresses leave `r0_q` and `r1_q` unchanged.
- R9: After a write to 0xD0, `r0_q` and `r1_q` equal the memory bytes at newbank*8+0 and newbank*8+1 from the next cycle on.
- R10: A write to any address that is neither an SFR mirror address nor an active-bank pointer address leaves every mirror output unchanged.
- R11: With `wr_en` low, memory and all mirror outputs keep their values whatever `wr_addr` and `wr_data` hold, and no bypass takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, write-first bypass |
| r0_q | output | 8 | Active-bank pointer register 0 copy |
| r1_q | output | 8 | Active-bank pointer register 1 copy |
| acc_q | output | 8 | Accumulator copy |
| sp_q | output | 8 | Stack pointer copy |
| dptr_q | output | 16 | Data pointer copy, high byte in 15:8 |
| psw_q | output | 8 | Status word copy |

## Verification
The read result is due in the same cycle as its address, while every mirror output is due one rising edge after the write that feeds it. The bench drives each cycle's inputs 2 ns after the rising edge and compares at the falling edge, so `rd_data` is judged against that cycle's inputs, bypass included. The mirror outputs at that falling edge are judged against the model state before that cycle's write, which means every write's effect on the mirrors is checked by the item of the following cycle. Bank pointer expectations come from the model memory at the bank given by the model status word, and they are checked only once both bytes of that bank have been written.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

    localparam int unsigned DW          = 8;
    localparam int unsigned AW          = 8;
    localparam int unsigned BANK_W      = 2;
    localparam int unsigned BANK_LSB    = 3;
    localparam int unsigned N_BANK_REGS = 2;

    localparam logic [AW-1:0] ADDR_ACC = 8'hE0;
    localparam logic [AW-1:0] ADDR_SP  = 8'h81;
    localparam logic [AW-1:0] ADDR_DPL = 8'h82;
    localparam logic [AW-1:0] ADDR_DPH = 8'h83;
    localparam logic [AW-1:0] ADDR_PSW = 8'hD0;

    localparam logic [DW-1:0] SP_RESET = 8'h07;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] sp;
        logic [DW-1:0] dpl;
        logic [DW-1:0] dph;
        logic [DW-1:0] psw;
    } sfr_t;

    // Address of pointer register idx inside the given bank (bank*8+idx).
    function automatic logic [AW-1:0] bank_reg_addr(input logic [BANK_W-1:0] bank,
                                                    input int unsigned idx);
        logic [AW-1:0] a;
        a = '0;
        a[BANK_LSB +: BANK_W] = bank;
        a = a + AW'(idx);
        return a;
    endfunction

    function automatic logic is_sfr_addr(input logic [AW-1:0] a);
        return (a == ADDR_ACC) || (a == ADDR_SP) || (a == ADDR_DPL) ||
               (a == ADDR_DPH) || (a == ADDR_PSW);
    endfunction

endpackage

// File: rtl/mrf_ram.sv
module mrf_ram
    import mrf_pkg::*;
#(
    parameter int unsigned N_AUX = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t                  wr,
    input  logic [AW-1:0]            rd_addr,
    output logic [DW-1:0]            rd_data,
    input  logic [N_AUX-1:0][AW-1:0] aux_addr,
    output logic [N_AUX-1:0][DW-1:0] aux_data
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Only the mirrored bytes get a reset value; the rest stays undefined.
    always_ff @(posedge clk) begin
        if (rst) begin
            mem[ADDR_ACC]            <= '0;
            mem[ADDR_SP]             <= SP_RESET;
            mem[ADDR_DPL]            <= '0;
            mem[ADDR_DPH]            <= '0;
            mem[ADDR_PSW]            <= '0;
            mem[bank_reg_addr('0, 0)] <= '0;
            mem[bank_reg_addr('0, 1)] <= '0;
        end else if (wr.en) begin
            mem[wr.addr] <= wr.data;
        end
    end

    // Write-first read port.
    always_comb begin
        if (wr.en && (wr.addr == rd_addr)) rd_data = wr.data;
        else                               rd_data = mem[rd_addr];
    end

    // Plain read ports used to reload the bank pointer copies.
    for (genvar g = 0; g < N_AUX; g++) begin : g_aux
        assign aux_data[g] = mem[aux_addr[g]];
    end

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> mem[$past(wr.addr)] == $past(wr.data));

endmodule

// File: rtl/mrf_sfr_mirror.sv
module mrf_sfr_mirror
    import mrf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr,
    output sfr_t    st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st.acc <= '0;
            st.sp  <= SP_RESET;
            st.dpl <= '0;
            st.dph <= '0;
            st.psw <= '0;
        end else if (wr.en) begin
            case (wr.addr)
                ADDR_ACC: st.acc <= wr.data;
                ADDR_SP:  st.sp  <= wr.data;
                ADDR_DPL: st.dpl <= wr.data;
                ADDR_DPH: st.dph <= wr.data;
                ADDR_PSW: st.psw <= wr.data;
                default:  ;
            endcase
        end
    end

    p_acc_follow_r4: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == ADDR_ACC) |=> st.acc == $past(wr.data));
    p_sp_follow_r5: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == ADDR_SP) |=> st.sp == $past(wr.data));
    p_dptr_follow_r6: assert property (@(posedge clk) disable iff (rst)
        (wr.en && (wr.addr == ADDR_DPL || wr.addr == ADDR_DPH)) |=>
            {st.dph, st.dpl} == ($past(wr.addr) == ADDR_DPH ?
                {$past(wr.data), $past(st.dpl)} : {$past(st.dph), $past(wr.data)}));
    p_psw_follow_r7: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == ADDR_PSW) |=> st.psw == $past(wr.data));
    p_sfr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (wr.en && !is_sfr_addr(wr.addr)) |=> $stable(st));
    p_sfr_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(st));

endmodule

// File: rtl/mrf_bank_mirror.sv
module mrf_bank_mirror
    import mrf_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  wr_req_t                        wr,
    input  logic [BANK_W-1:0]              bank_now,
    output logic [N_BANK_REGS-1:0][AW-1:0] aux_addr,
    input  logic [N_BANK_REGS-1:0][DW-1:0] aux_data,
    output logic [DW-1:0]                  r0,
    output logic [DW-1:0]                  r1
);
    logic              psw_wr;
    logic [BANK_W-1:0] bank_next;
    logic [DW-1:0]     regs [N_BANK_REGS];

    assign psw_wr    = wr.en && (wr.addr == ADDR_PSW);
    assign bank_next = psw_wr ? wr.data[BANK_LSB +: BANK_W] : bank_now;

    for (genvar i = 0; i < N_BANK_REGS; i++) begin : g_ptr
        // Look-ahead address: the bank that will be active after this edge.
        assign aux_addr[i] = bank_reg_addr(bank_next, i);

        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (psw_wr)
                regs[i] <= aux_data[i];
            else if (wr.en && wr.addr == bank_reg_addr(bank_now, i))
                regs[i] <= wr.data;
        end
    end

    assign r0 = regs[0];
    assign r1 = regs[1];

    p_r0_write_r8: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == bank_reg_addr(bank_now, 0)) |=> r0 == $past(wr.data));
    p_r1_write_r8: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == bank_reg_addr(bank_now, 1)) |=> r1 == $past(wr.data));
    // Between status-word writes the copies must match the RAM bytes of the active bank.
    p_coherent_r9: assert property (@(posedge clk) disable iff (rst)
        !psw_wr |-> (r0 == aux_data[0]) && (r1 == aux_data[1]));
    p_bank_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (wr.en && !psw_wr && wr.addr != bank_reg_addr(bank_now, 0) &&
         wr.addr != bank_reg_addr(bank_now, 1)) |=> ($stable(r0) && $stable(r1)));

endmodule

// File: rtl/mirror_regfile.sv
module mirror_regfile
    import mrf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [7:0]    rd_addr,
    output logic [7:0]    rd_data,
    output logic [7:0]    r0_q,
    output logic [7:0]    r1_q,
    output logic [7:0]    acc_q,
    output logic [7:0]    sp_q,
    output logic [15:0]   dptr_q,
    output logic [7:0]    psw_q
);
    wr_req_t                        wr;
    sfr_t                           sfr;
    logic [N_BANK_REGS-1:0][AW-1:0] aux_addr;
    logic [N_BANK_REGS-1:0][DW-1:0] aux_data;

    assign wr = '{en: wr_en, addr: wr_addr, data: wr_data};

    mrf_ram #(.N_AUX(N_BANK_REGS)) u_ram (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .aux_addr (aux_addr),
        .aux_data (aux_data)
    );

    mrf_sfr_mirror u_sfr (
        .clk (clk),
        .rst (rst),
        .wr  (wr),
        .st  (sfr)
    );

    mrf_bank_mirror u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .bank_now (sfr.psw[BANK_LSB +: BANK_W]),
        .aux_addr (aux_addr),
        .aux_data (aux_data),
        .r0       (r0_q),
        .r1       (r1_q)
    );

    assign acc_q  = sfr.acc;
    assign sp_q   = sfr.sp;
    assign dptr_q = {sfr.dph, sfr.dpl};
    assign psw_q  = sfr.psw;

endmodule

// File: tb/mirror_regfile_test.sv
`timescale 1ns/1ps
module mirror_regfile_test;

    typedef struct packed {
        logic [31:0] tag;
        logic        rd_ok;
        logic [7:0]  rd;
        logic [7:0]  acc;
        logic [7:0]  sp;
        logic [15:0] dptr;
        logic [7:0]  psw;
        logic        r_ok;
        logic [7:0]  r0;
        logic [7:0]  r1;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0]  rd_data, r0_q, r1_q, acc_q, sp_q, psw_q;
    logic [15:0] dptr_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_t        sb_q[$];
    logic [7:0]  mdl   [256];
    bit          known [256];

    always #4 clk = ~clk;   // 125 MHz

    mirror_regfile uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .r0_q(r0_q), .r1_q(r1_q),
        .acc_q(acc_q), .sp_q(sp_q), .dptr_q(dptr_q), .psw_q(psw_q)
    );

    task automatic chk(input logic [31:0] tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expectation pushed to the scoreboard.
    task automatic step(input logic en, input logic [7:0] a, input logic [7:0] d,
                        input logic [7:0] ra, input logic [31:0] tag);
        exp_t e;
        logic [7:0] b;
        @(posedge clk);
        #2;
        wr_en = en; wr_addr = a; wr_data = d; rd_addr = ra;
        e.tag   = tag;
        e.acc   = mdl[8'hE0];
        e.sp    = mdl[8'h81];
        e.dptr  = {mdl[8'h83], mdl[8'h82]};
        e.psw   = mdl[8'hD0];
        b       = {3'b000, mdl[8'hD0][4:3], 3'b000};
        e.r_ok  = known[b] && known[b + 8'd1];
        e.r0    = mdl[b];
        e.r1    = mdl[b + 8'd1];
        if (en && a == ra) begin e.rd_ok = 1'b1; e.rd = d; end
        else begin e.rd_ok = known[ra]; e.rd = mdl[ra]; end
        sb_q.push_back(e);
        if (en) begin mdl[a] = d; known[a] = 1'b1; end
    endtask

    // Monitor: compares at the falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.rd_ok) chk(e.tag, "rd_data", {8'h00, rd_data}, {8'h00, e.rd});
            chk(e.tag, "acc_q",  {8'h00, acc_q}, {8'h00, e.acc});
            chk(e.tag, "sp_q",   {8'h00, sp_q},  {8'h00, e.sp});
            chk(e.tag, "dptr_q", dptr_q,         e.dptr);
            chk(e.tag, "psw_q",  {8'h00, psw_q}, {8'h00, e.psw});
            if (e.r_ok) begin
                chk(e.tag, "r0_q", {8'h00, r0_q}, {8'h00, e.r0});
                chk(e.tag, "r1_q", {8'h00, r1_q}, {8'h00, e.r1});
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL all: watchdog expired, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin mdl[i] = '0; known[i] = 1'b0; end
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // Model of the reset state (R1).
        mdl[8'h81] = 8'h07;
        known[8'h81] = 1'b1; known[8'hE0] = 1'b1; known[8'h82] = 1'b1;
        known[8'h83] = 1'b1; known[8'hD0] = 1'b1; known[8'h00] = 1'b1; known[8'h01] = 1'b1;

        // R1: reset values through both the read port and the mirror outputs
        step(1'b0, 8'h00, 8'h00, 8'h81, "R1");
        step(1'b0, 8'h00, 8'h00, 8'hE0, "R1");
        step(1'b0, 8'h00, 8'h00, 8'h82, "R1");
        step(1'b0, 8'h00, 8'h00, 8'h83, "R1");
        step(1'b0, 8'h00, 8'h00, 8'hD0, "R1");
        step(1'b0, 8'h00, 8'h00, 8'h00, "R1");
        step(1'b0, 8'h00, 8'h00, 8'h01, "R1");

        // R2: plain store then later read
        step(1'b1, 8'h30, 8'hA5, 8'h00, "R2");
        step(1'b0, 8'h00, 8'h00, 8'h30, "R2");
        // R3: same-cycle bypass, and a non-matching write does not bypass
        step(1'b1, 8'h40, 8'h3C, 8'h40, "R3");
        step(1'b1, 8'h41, 8'h77, 8'h40, "R3");
        step(1'b1, 8'h41, 8'h78, 8'h41, "R3");

        // R4..R7: SFR mirrors
        step(1'b1, 8'hE0, 8'h5A, 8'hE0, "R4");
        step(1'b1, 8'h81, 8'h2F, 8'hE0, "R5");
        step(1'b1, 8'h82, 8'h34, 8'h81, "R6");
        step(1'b1, 8'h83, 8'h12, 8'h82, "R6");
        step(1'b1, 8'hD0, 8'h01, 8'h83, "R7");
        step(1'b0, 8'h00, 8'h00, 8'hD0, "R7");

        // R8: bank 0 pointer writes, and fills of other banks that must not disturb them
        step(1'b1, 8'h00, 8'h11, 8'h00, "R8");
        step(1'b1, 8'h01, 8'h22, 8'h01, "R8");
        step(1'b1, 8'h08, 8'h88, 8'h00, "R8");
        step(1'b1, 8'h09, 8'h99, 8'h00, "R8");
        step(1'b1, 8'h10, 8'hAA, 8'h00, "R8");
        step(1'b1, 8'h11, 8'hBB, 8'h00, "R8");
        step(1'b1, 8'h18, 8'hCC, 8'h00, "R8");
        step(1'b1, 8'h19, 8'hDD, 8'h00, "R8");

        // R9: bank switches reload the pointer copies
        step(1'b1, 8'hD0, 8'h08, 8'h08, "R9");
        step(1'b1, 8'hD0, 8'h10, 8'h10, "R9");
        step(1'b1, 8'hD0, 8'h18, 8'h18, "R9");
        step(1'b1, 8'h18, 8'h5E, 8'h18, "R8");
        step(1'b1, 8'h01, 8'h66, 8'h01, "R8");
        step(1'b1, 8'hD0, 8'h1F, 8'hD0, "R9");
        step(1'b1, 8'hD0, 8'h00, 8'h00, "R9");
        step(1'b0, 8'h00, 8'h00, 8'h01, "R9");

        // R10: writes outside every mirrored address
        step(1'b1, 8'h20, 8'h55, 8'h20, "R10");
        step(1'b1, 8'h7F, 8'h56, 8'h20, "R10");
        step(1'b1, 8'hFF, 8'h57, 8'h7F, "R10");
        step(1'b1, 8'h84, 8'h58, 8'hFF, "R10");
        step(1'b1, 8'h80, 8'h59, 8'h84, "R10");
        step(1'b1, 8'h02, 8'h5B, 8'h80, "R10");

        // R11: disabled writes with live-looking address and data
        step(1'b0, 8'hE0, 8'hFF, 8'hE0, "R11");
        step(1'b0, 8'h00, 8'hFF, 8'h00, "R11");
        step(1'b0, 8'hD0, 8'h18, 8'hD0, "R11");
        step(1'b0, 8'h30, 8'h00, 8'h30, "R11");

        @(posedge clk);
        #2 wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule